// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a blocking data cache that sits between a load/store unit and a line-wide memory port. The address splits into a tag, a set index and a line offset. A set has two ways, and a line may live in either one. Both ways are looked up in parallel. A load hit returns its word on the cycle after the request is accepted. A store hit only changes the cached copy and marks the line dirty.

On a miss the cache stops taking requests and runs a short sequence: Ready, StartMiss, SendFillReq, WaitFillResp, then Ready again.
- In StartMiss it picks a victim way. If that victim is dirty, it queues a write-back of the whole line.
- In SendFillReq it queues a read for the missing line.
- When the fill arrives, the line is installed. A load installs it clean and returns the word. A store merges its word first and installs the line dirty.

Memory requests leave through a two-entry queue with a valid/ready handshake. The fill response is a single-cycle valid pulse.

Top module: `dcache_2way`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mreq_valid` is 0. No way holds a valid line, so the first access to any address is a miss.
- R2: The request tag is compared against both ways of the set chosen by address bits [7:4], in the same cycle. A load that hits in either way raises `resp_valid` with that way's word on the cycle after acceptance, and issues no memory request.
- R3: A store hit writes only the addressed cached word and marks the line dirty. It issues no memory request, and a later load of that word returns the stored value.
- R4: A store miss first fetches the whole line. It then overwrites the addressed word, and the line is kept as dirty.
- R5: After a miss is accepted, `req_ready` stays 0 until the miss completes. The fill request has `mreq_write`=0 and the line address (address bits [3:0] cleared).
- R6: The victim is chosen in this order:
  - an invalid way, taking way 0 before way 1;
  - otherwise a clean way over a dirty one;
  - otherwise, when both ways are clean or both are dirty, the least recently used way.
- R7: A dirty victim is written back before the fill request is sent. The write-back has `mreq_write`=1, an address made of the victim's stored tag, the set index and a zero 4-bit offset, and it carries the whole 128-bit line.
- R8: A load miss installs the fill line as clean. It returns the requested word on the cycle after the fill response.
- R9: Address bits [3:2] pick word k of a line. Word k occupies line bits [32k+31:32k] on both `mreq_line` and `mresp_line`.
- R10: Each set keeps a recency bit. Every hit and every fill marks the used way as most recent.
- R11: Memory requests pass through a 2-entry queue. While `mreq_valid` is 1 and `mreq_ready` is 0, `mreq_valid`, `mreq_addr` and the rest of the request hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request (idle state) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Load word available (one-cycle pulse) |
| resp_rdata | output | 32 | Load word |
| mreq_valid | output | 1 | Memory request present |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_write | output | 1 | 1 = line write-back, 0 = line fill |
| mreq_addr | output | 32 | Line-aligned memory address |
| mreq_line | output | 128 | Write-back line data |
| mresp_valid | input | 1 | Fill line present (one-cycle pulse) |
| mresp_line | input | 128 | Fill line data |

## Verification
The bench builds the cache with its default parameters: 32-bit addresses and words, 16 sets and 4-word lines. With only 16 sets, a few tags that share one index force every victim decision:
- an empty way;
- a clean way beside a dirty one;
- two clean ways, and two dirty ways, where the recency bit decides.

A memory model with a fixed fill latency and injected ready stalls lets the bench observe the order of write-back and fill, and check that queued requests hold steady under back-pressure.

// File: rtl/dc2w_pkg.sv
package dc2w_pkg;
  typedef enum logic [1:0] {
    ST_READY    = 2'd0,
    ST_START    = 2'd1,
    ST_FILLREQ  = 2'd2,
    ST_WAITFILL = 2'd3
  } dc_state_e;
endpackage

// File: rtl/dc2w_way.sv
module dc2w_way #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 24,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_dirty,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = line_q[rd_idx];
endmodule

// File: rtl/dc2w_victim.sv
module dc2w_victim (
  input  logic [1:0] way_valid,
  input  logic [1:0] way_dirty,
  input  logic       lru_way,
  output logic       victim
);
  always_comb begin
    if (!way_valid[0])                   victim = 1'b0;
    else if (!way_valid[1])              victim = 1'b1;
    else if (way_dirty[0] != way_dirty[1]) victim = way_dirty[0];
    else                                 victim = lru_way;
  end
endmodule

// File: rtl/dc2w_req_fifo.sv
module dc2w_req_fifo #(
  parameter int W = 161
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic [W-1:0] slot_q [2];
  logic         wp_q, rp_q;
  logic [1:0]   cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 2'd1;
    else if (pop && !push) cnt_d = cnt_q - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= 1'b0;
      rp_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else begin
      cnt_q <= cnt_d;
      if (push) wp_q <= ~wp_q;
      if (pop)  rp_q <= ~rp_q;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= push_data;
  end

  assign full      = (cnt_q == 2'd2);
  assign out_valid = (cnt_q != 2'd0);
  assign out_data  = slot_q[rp_q];

  // R11
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R11
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> out_valid);
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way
  import dc2w_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int WSEL_W = 2,
  parameter int BYTE_W = 2,
  localparam int WORDS  = 1 << WSEL_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [LINE_W-1:0] mreq_line,
  input  logic              mresp_valid,
  input  logic [LINE_W-1:0] mresp_line
);
  localparam int OFF_W = WSEL_W + BYTE_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int MQ_W  = 1 + ADDR_W + LINE_W;

  dc_state_e state_q, state_d;

  logic              miss_write_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic [DATA_W-1:0] miss_wdata_q;
  logic              vic_q;
  logic [SETS-1:0]   lru_q;
  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_data_q;

  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic [WSEL_W-1:0] look_wsel;
  logic              unused_byte;

  logic [1:0]        w_valid, w_dirty, w_wr, hit_way;
  logic [TAG_W-1:0]  w_tag  [2];
  logic [LINE_W-1:0] w_line [2];
  logic [TAG_W-1:0]  wr_tag;
  logic              wr_dirty;
  logic [LINE_W-1:0] wr_line;

  logic              hit, hsel, vic_pick, vic_load;
  logic              resp_set, lru_upd, lru_way;
  logic [DATA_W-1:0] resp_word;
  logic              q_push, q_full, q_pop;
  logic [MQ_W-1:0]   q_in, q_out;

  function automatic logic [LINE_W-1:0] merge_word(
    input logic [LINE_W-1:0] line,
    input logic [WSEL_W-1:0] sel,
    input logic [DATA_W-1:0] word
  );
    logic [LINE_W-1:0] r;
    r = line;
    r[sel*DATA_W +: DATA_W] = word;
    return r;
  endfunction

  // Lookup address: the live request while idle, the held miss otherwise
  assign look_addr   = (state_q == ST_READY) ? req_addr : miss_addr_q;
  assign look_idx    = look_addr[OFF_W +: IDX_W];
  assign look_tag    = look_addr[ADDR_W-1 -: TAG_W];
  assign look_wsel   = look_addr[BYTE_W +: WSEL_W];
  assign unused_byte = ^look_addr[BYTE_W-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_way
    dc2w_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (look_idx),
      .rd_valid (w_valid[w]),
      .rd_dirty (w_dirty[w]),
      .rd_tag   (w_tag[w]),
      .rd_line  (w_line[w]),
      .wr_en    (w_wr[w]),
      .wr_idx   (look_idx),
      .wr_tag   (wr_tag),
      .wr_dirty (wr_dirty),
      .wr_line  (wr_line)
    );
    assign hit_way[w] = w_valid[w] && (w_tag[w] == look_tag);
  end

  assign hit  = |hit_way;
  assign hsel = hit_way[1];

  dc2w_victim u_victim (
    .way_valid (w_valid),
    .way_dirty (w_dirty),
    .lru_way   (lru_q[look_idx]),
    .victim    (vic_pick)
  );

  always_comb begin
    state_d   = state_q;
    w_wr      = '0;
    wr_tag    = look_tag;
    wr_dirty  = 1'b0;
    wr_line   = w_line[hsel];
    resp_set  = 1'b0;
    resp_word = w_line[hsel][look_wsel*DATA_W +: DATA_W];
    lru_upd   = 1'b0;
    lru_way   = hsel;
    q_push    = 1'b0;
    q_in      = '0;
    vic_load  = 1'b0;
    case (state_q)
      ST_READY: begin
        if (req_valid) begin
          if (hit) begin
            lru_upd = 1'b1;
            if (req_write) begin
              w_wr[hsel] = 1'b1;
              wr_dirty   = 1'b1;
              wr_line    = merge_word(w_line[hsel], look_wsel, req_wdata);
            end else begin
              resp_set = 1'b1;
            end
          end else begin
            state_d = ST_START;
          end
        end
      end
      ST_START: begin
        vic_load = 1'b1;
        if (w_valid[vic_pick] && w_dirty[vic_pick]) begin
          if (!q_full) begin
            q_push  = 1'b1;
            q_in    = {1'b1, w_tag[vic_pick], look_idx, {OFF_W{1'b0}}, w_line[vic_pick]};
            state_d = ST_FILLREQ;
          end
        end else begin
          state_d = ST_FILLREQ;
        end
      end
      ST_FILLREQ: begin
        if (!q_full) begin
          q_push  = 1'b1;
          q_in    = {1'b0, look_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}, {LINE_W{1'b0}}};
          state_d = ST_WAITFILL;
        end
      end
      default: begin
        if (mresp_valid) begin
          w_wr[vic_q] = 1'b1;
          wr_dirty    = miss_write_q;
          wr_line     = miss_write_q ? merge_word(mresp_line, look_wsel, miss_wdata_q)
                                     : mresp_line;
          resp_set    = !miss_write_q;
          resp_word   = mresp_line[look_wsel*DATA_W +: DATA_W];
          lru_upd     = 1'b1;
          lru_way     = vic_q;
          state_d     = ST_READY;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_READY;
      resp_valid_q <= 1'b0;
      lru_q        <= '0;
      vic_q        <= 1'b0;
    end else begin
      state_q      <= state_d;
      resp_valid_q <= resp_set;
      if (lru_upd)  lru_q[look_idx] <= ~lru_way;
      if (vic_load) vic_q <= vic_pick;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_READY && req_valid && !hit) begin
      miss_write_q <= req_write;
      miss_addr_q  <= req_addr;
      miss_wdata_q <= req_wdata;
    end
    if (resp_set) resp_data_q <= resp_word;
  end

  dc2w_req_fifo #(.W(MQ_W)) u_mq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (q_in),
    .full      (q_full),
    .pop       (q_pop),
    .out_valid (mreq_valid),
    .out_data  (q_out)
  );

  assign q_pop      = mreq_valid && mreq_ready;
  assign mreq_write = q_out[MQ_W-1];
  assign mreq_addr  = q_out[LINE_W +: ADDR_W];
  assign mreq_line  = q_out[LINE_W-1:0];
  assign req_ready  = (state_q == ST_READY);
  assign resp_valid = resp_valid_q;
  assign resp_rdata = resp_data_q;

  // R2
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY && req_valid) |-> !(hit_way[0] && hit_way[1]));

  // R5
  miss_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !hit) |=> !req_ready);

  // R6
  victim_invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && !(w_valid[0] && w_valid[1])) |-> !w_valid[vic_pick]);

  // R8
  fill_load_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAITFILL && mresp_valid && !miss_write_q) |=> (resp_valid && req_ready));

  // R10
  lru_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY && req_valid && hit) |=> (lru_q[$past(look_idx)] != $past(hsel)));

  // R11
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_write)
                                     && $stable(mreq_line)));
endmodule

// File: tb/tb_dcache_2way.sv
`timescale 1ns/1ps
module tb_dcache_2way;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready, req_write;
  logic [31:0]  req_addr, req_wdata;
  logic         resp_valid;
  logic [31:0]  resp_rdata;
  logic         mreq_valid, mreq_ready, mreq_write;
  logic [31:0]  mreq_addr;
  logic [127:0] mreq_line;
  logic         mresp_valid;
  logic [127:0] mresp_line;

  always #2 clk = ~clk;

  dcache_2way dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_addr(mreq_addr), .mreq_line(mreq_line),
    .mresp_valid(mresp_valid), .mresp_line(mresp_line)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit [31:0]  mem  [bit [31:0]];
  bit [31:0]  gold [bit [31:0]];
  bit         lq_w [$];
  bit [31:0]  lq_a [$];
  bit [127:0] lq_l [$];
  int         fill_cyc = 0;
  int         stall_n  = 0;

  bit        m_v   [16][2];
  bit        m_d   [16][2];
  bit [23:0] m_t   [16][2];
  bit        m_lru [16];

  function automatic bit [31:0] dflt(bit [31:0] a);
    return a ^ 32'h5A00_C3E1;
  endfunction
  function automatic bit [31:0] rd_mem(bit [31:0] a);
    return mem.exists(a) ? mem[a] : dflt(a);
  endfunction
  function automatic bit [31:0] rd_gold(bit [31:0] a);
    return gold.exists(a) ? gold[a] : dflt(a);
  endfunction
  function automatic bit [127:0] gold_line(bit [31:0] base);
    bit [127:0] r;
    for (int k = 0; k < 4; k++) r[k*32 +: 32] = rd_gold(base + 32'(4*k));
    return r;
  endfunction
  function automatic bit [31:0] mk(int t, int i, int w);
    return {t[23:0], i[3:0], w[1:0], 2'b00};
  endfunction

  task automatic check(string rq, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Memory model: fixed fill latency, optional ready stalls
  initial begin : memory_model
    bit [31:0] fill_addr = 0;
    int        fill_cnt = -1;
    bit        hold_chk = 0;
    bit [31:0] hold_addr = 0;
    mreq_ready  = 1'b0;
    mresp_valid = 1'b0;
    mresp_line  = '0;
    forever begin
      @(negedge clk);
      mresp_valid = 1'b0;
      if (hold_chk) begin
        check("R11", "request held under stall", {mreq_valid, mreq_addr}, {1'b1, hold_addr});
        hold_chk = 0;
      end
      if (fill_cnt > 0) fill_cnt--;
      else if (fill_cnt == 0) begin
        for (int k = 0; k < 4; k++) mresp_line[k*32 +: 32] = rd_mem(fill_addr + 32'(4*k));
        mresp_valid = 1'b1;
        fill_cyc    = cyc;
        fill_cnt    = -1;
      end
      mreq_ready = (stall_n == 0);
      if (stall_n > 0) stall_n--;
      if (mreq_valid && mreq_ready) begin
        lq_w.push_back(mreq_write);
        lq_a.push_back(mreq_addr);
        lq_l.push_back(mreq_line);
        if (mreq_write) begin
          for (int k = 0; k < 4; k++) mem[mreq_addr + 32'(4*k)] = mreq_line[k*32 +: 32];
        end else begin
          fill_addr = mreq_addr;
          fill_cnt  = 2;
        end
      end else if (mreq_valid) begin
        hold_chk  = 1;
        hold_addr = mreq_addr;
      end
    end
  end

  task automatic access(bit wr, bit [31:0] a, bit [31:0] d, string rq);
    int        idx  = int'(a[7:4]);
    bit [23:0] t    = a[31:8];
    bit [31:0] la   = {a[31:4], 4'b0};
    int        hw   = -1;
    int        nlog = lq_w.size();
    int        vw;
    bit        wb;
    bit [31:0] wb_a;
    bit [127:0] wb_l;
    for (int w = 0; w < 2; w++) if (m_v[idx][w] && m_t[idx][w] == t) hw = w;
    for (int k = 0; k < 300 && !req_ready; k++) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (hw >= 0) begin
      check({rq, " R2"}, "hit keeps ready", req_ready, 1);
      if (!wr) begin
        check({rq, " R2"}, "hit resp_valid", resp_valid, 1);
        check({rq, " R9"}, "hit word", resp_rdata, rd_gold(a));
      end else begin
        gold[a] = d;
        m_d[idx][hw] = 1;
        check({rq, " R3"}, "no memory traffic on store hit",
              {31'(lq_w.size() - nlog), mreq_valid}, 0);
      end
      m_lru[idx] = (hw == 0);
    end else begin
      check({rq, " R5"}, "miss drops ready", req_ready, 0);
      if (!m_v[idx][0]) vw = 0;
      else if (!m_v[idx][1]) vw = 1;
      else if (m_d[idx][0] != m_d[idx][1]) vw = m_d[idx][0] ? 1 : 0;
      else vw = m_lru[idx] ? 1 : 0;
      wb   = m_v[idx][vw] && m_d[idx][vw];
      wb_a = {m_t[idx][vw], a[7:4], 4'b0};
      wb_l = gold_line(wb_a);
      for (int k = 0; k < 400; k++) begin
        if (req_ready) break;
        check({rq, " R5"}, "no response while busy", resp_valid, 0);
        @(negedge clk);
      end
      if (!wr) begin
        check({rq, " R8"}, "load miss resp_valid", resp_valid, 1);
        check({rq, " R8"}, "load miss word", resp_rdata, rd_gold(a));
        check({rq, " R8"}, "resp one cycle after fill", cyc, fill_cyc + 1);
      end else begin
        gold[a] = d;
        check({rq, " R4"}, "store miss no resp", resp_valid, 0);
      end
      check({rq, " R7"}, "memory request count", lq_w.size() - nlog, wb ? 2 : 1);
      if (lq_w.size() - nlog == (wb ? 2 : 1)) begin
        if (wb) begin
          check({rq, " R7"}, "write-back kind", lq_w[nlog], 1);
          check({rq, " R7"}, "write-back address", lq_a[nlog], wb_a);
          check({rq, " R7"}, "write-back line", lq_l[nlog], wb_l);
          nlog++;
        end
        check({rq, " R5"}, "fill kind", lq_w[nlog], 0);
        check({rq, " R5"}, "fill address", lq_a[nlog], la);
      end
      m_v[idx][vw] = 1; m_t[idx][vw] = t; m_d[idx][vw] = wr;
      m_lru[idx] = (vw == 0);
    end
  endtask

  initial begin : main
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    for (int s = 0; s < 16; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset req_ready", req_ready, 1);
    check("R1", "reset resp_valid", resp_valid, 0);
    check("R1", "reset mreq_valid", mreq_valid, 0);

    access(0, mk(1, 3, 1), 0, "R1 cold load");
    access(0, mk(1, 3, 2), 0, "R2 same line");
    access(0, mk(2, 3, 0), 0, "R6 invalid way");
    access(0, mk(1, 3, 3), 0, "R2 way0");
    access(0, mk(2, 3, 1), 0, "R2 way1");
    access(1, mk(1, 3, 0), 32'hDEAD_0001, "R3 store hit");
    access(0, mk(1, 3, 0), 0, "R3 readback");
    access(0, mk(2, 3, 2), 0, "R10 touch clean");
    access(0, mk(3, 3, 2), 0, "R6 clean over dirty");
    access(0, mk(1, 3, 1), 0, "R6 dirty kept");

    access(1, mk(4, 5, 2), 32'hBEEF_0042, "R4 store miss");
    for (int w = 0; w < 4; w++) access(0, mk(4, 5, w), 0, "R9 word select");

    access(1, mk(3, 3, 1), 32'h0123_4567, "R7 make both dirty");
    access(0, mk(5, 3, 0), 0, "R7 dirty lru victim");
    access(0, mk(3, 3, 1), 0, "R7 survivor");

    access(0, mk(6, 7, 0), 0, "R10 X");
    access(0, mk(7, 7, 0), 0, "R10 Y");
    access(0, mk(6, 7, 1), 0, "R10 X again");
    access(0, mk(8, 7, 0), 0, "R10 Z evicts Y");
    access(0, mk(6, 7, 2), 0, "R10 X kept");
    access(0, mk(7, 7, 3), 0, "R10 Y refetch");

    access(1, mk(5, 3, 3), 32'hCAFE_F00D, "R11 dirty again");
    stall_n = 6;
    access(0, mk(9, 3, 0), 0, "R11 stalled evict");
    access(0, mk(3, 3, 1), 0, "R11 written-back data");
    access(0, mk(5, 3, 3), 0, "R11 other way");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule